// File: doc/BRIEF.md
# Stochastic Probabilistic Bit Unit

This block produces a single random telegraph bit whose long-run fraction of ones is set by a signed 8-bit bias. When it resamples, it looks up an 8-bit probability for the bias on a saturating S-shaped curve. It compares that probability with the upper byte of a free-running 16-bit maximal-length LFSR and takes the result as its new output. It then freezes the bit for a programmable number of clocks. After that interval it resamples again.

Each instance carries its own LFSR seed, and each has its own hold count on a port. Many copies can therefore run side by side with no shared update strobe. Their resample instants differ, so across a network the copies update one at a time rather than all at once. A clamp control pins the next resampled value to a chosen rail. This acts like a very large bias. The bias and hold count are plain level inputs that are sampled only at a resample, so there is no handshake and no back-pressure.

Top module: `pbit_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `state_out` becomes 0 and the hold timer is cleared. The first rising edge with `rst` low is a resample.
- R2: At a resample the timer loads `hold_cycles` = H. `state_out` then stays constant for the next H edges, and the edge after those is the next resample. Resamples are therefore H+1 clocks apart.
- R3: With `hold_cycles` = 0 the unit resamples on every clock edge.
- R4: The probability for bias x (two's complement, -128..127) is p = 128 + trunc(127*x/(|x|+32)). The value at x = -128 is 0 and the value at x = 127 is 255. At a resample the new bit is 1 when p exceeds the upper LFSR byte, or when p = 255.
- R5: A bias of -128 (8'h80) always resamples to 0, and a bias of 127 (8'h7F) always resamples to 1.
- R6: A bias of 0 gives ones on half of the resamples, within sampling tolerance.
- R7: When `clamp_en` is 1 at a resample, the new bit equals `clamp_val`, whatever the bias.
- R8: Over many resamples, the fraction of ones is p/256 for bias values between the rails, within ±4 %.
- R9: `hold_cycles` is read only at a resample. A change in the middle of a hold does not shorten or lengthen that hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bias_in | input | 8 | Signed bias, two's complement |
| hold_cycles | input | 24 | Hold count loaded at each resample |
| clamp_en | input | 1 | Forces the next resample to `clamp_val` |
| clamp_val | input | 1 | Value forced when clamped |
| state_out | output | 1 | Stochastic output bit |

## Verification
A hold timer that reloads or decrements wrongly changes when `state_out` moves. The bench catches this with rail-valued biases: the output is then deterministic, and a transition one clock early or late shows at the first resample after the fault. A faulty curve entry or a bad comparison does not show in any single cycle. It appears as a biased ones count over a few thousand resamples, so the statistical vectors are the check for that. A broken LFSR stalls the output at a constant, and the mid-range vectors expose that within one window.

// File: rtl/pbit_pkg.sv
package pbit_pkg;
  localparam int BIAS_W = 8;
  localparam int PROB_W = 8;
  localparam int RNG_W  = 16;
  localparam int CURVE_N = 1 << BIAS_W;

  // saturating S-curve: 128 + 127*x/(|x|+k), exact rails at the extremes
  function automatic logic [PROB_W-1:0] curve_at(input int x, input int k);
    int ax;
    int v;
    if (x <= -(CURVE_N/2)) return '0;
    if (x >= (CURVE_N/2) - 1) return '1;
    ax = (x < 0) ? -x : x;
    v = 128 + (127 * x) / (ax + k);
    return PROB_W'(v);
  endfunction
endpackage

// File: rtl/pbit_lfsr.sv
module pbit_lfsr
  import pbit_pkg::*;
#(
  parameter logic [RNG_W-1:0] SEED = 16'hACE1,
  parameter int OUT_W = PROB_W
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd_o
);
  localparam logic [RNG_W-1:0] START = (SEED == '0) ? RNG_W'(1) : SEED;

  logic [RNG_W-1:0] sreg;
  logic             fb;

  // x^16 + x^14 + x^13 + x^11 + 1
  assign fb = sreg[15] ^ sreg[13] ^ sreg[12] ^ sreg[10];

  always_ff @(posedge clk) begin
    if (rst) sreg <= START;
    else     sreg <= {sreg[RNG_W-2:0], fb};
  end

  assign rnd_o = sreg[RNG_W-1 -: OUT_W];
endmodule

// File: rtl/pbit_curve_rom.sv
module pbit_curve_rom
  import pbit_pkg::*;
#(
  parameter int SLOPE_K = 32
) (
  input  logic [BIAS_W-1:0] bias_i,
  output logic [PROB_W-1:0] prob_o
);
  localparam int TBL_BITS = CURVE_N * PROB_W;

  function automatic logic [TBL_BITS-1:0] build_tbl();
    logic [TBL_BITS-1:0] t;
    t = '0;
    for (int i = 0; i < CURVE_N; i++) begin
      int x;
      x = (i >= CURVE_N/2) ? i - CURVE_N : i;
      t[i*PROB_W +: PROB_W] = curve_at(x, SLOPE_K);
    end
    return t;
  endfunction

  localparam logic [TBL_BITS-1:0] TBL = build_tbl();

  assign prob_o = TBL[bias_i*PROB_W +: PROB_W];
endmodule

// File: rtl/pbit_hold_timer.sv
module pbit_hold_timer #(
  parameter int HOLD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HOLD_W-1:0] reload_i,
  output logic              fire_o,
  output logic [HOLD_W-1:0] cnt_o
);
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (cnt_q == '0) cnt_q <= reload_i;
    else                  cnt_q <= cnt_q - 1'b1;
  end

  assign fire_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pbit_unit.sv
module pbit_unit
  import pbit_pkg::*;
#(
  parameter logic [RNG_W-1:0] SEED = 16'hACE1,
  parameter int HOLD_W  = 24,
  parameter int SLOPE_K = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BIAS_W-1:0] bias_in,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              clamp_en,
  input  logic              clamp_val,
  output logic              state_out
);
  logic [PROB_W-1:0] prob;
  logic [PROB_W-1:0] rnd;
  logic              fire;
  logic [HOLD_W-1:0] cnt_q;
  logic              draw;
  logic              state_q;

  pbit_lfsr #(.SEED(SEED), .OUT_W(PROB_W)) u_rng (
    .clk(clk), .rst(rst), .rnd_o(rnd)
  );

  pbit_curve_rom #(.SLOPE_K(SLOPE_K)) u_curve (
    .bias_i(bias_in), .prob_o(prob)
  );

  pbit_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk(clk), .rst(rst), .reload_i(hold_cycles),
    .fire_o(fire), .cnt_o(cnt_q)
  );

  // full-scale probability counts as certain
  always_comb begin
    if (clamp_en) draw = clamp_val;
    else          draw = (prob == '1) || (prob > rnd);
  end

  always_ff @(posedge clk) begin
    if (rst)       state_q <= 1'b0;
    else if (fire) state_q <= draw;
  end

  assign state_out = state_q;
endmodule

// File: rtl/pbit_unit_chk.sv
module pbit_unit_chk #(
  parameter int HOLD_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        bias_in,
  input logic [HOLD_W-1:0] hold_cycles,
  input logic              clamp_en,
  input logic              clamp_val,
  input logic [HOLD_W-1:0] cnt_q,
  input logic              state_out
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (state_out == 1'b0 && cnt_q == '0));

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> $stable(state_out));

  a_r9_reload_value: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |=> (cnt_q == $past(hold_cycles)));

  a_r3_every_clock: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && hold_cycles == '0) |=> (cnt_q == '0));

  a_r5_floor: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !clamp_en && bias_in == 8'h80) |=> !state_out);

  a_r5_ceiling: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !clamp_en && bias_in == 8'h7F) |=> state_out);

  a_r7_clamp: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && clamp_en) |=> (state_out == $past(clamp_val)));
endmodule

bind pbit_unit pbit_unit_chk #(.HOLD_W(HOLD_W)) u_chk (
  .clk(clk), .rst(rst), .bias_in(bias_in), .hold_cycles(hold_cycles),
  .clamp_en(clamp_en), .clamp_val(clamp_val), .cnt_q(cnt_q),
  .state_out(state_out)
);

// File: tb/test_pbit_unit.sv
module test_pbit_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bias_in = 8'h7F;
  logic [23:0] hold_cycles = 24'd0;
  logic        clamp_en = 1'b0;
  logic        clamp_val = 1'b0;
  logic        state_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  localparam int WIN = 8192;
  localparam int TOL = 328;
  localparam int NV  = 7;
  localparam logic signed [7:0] VEC_X [NV] = '{8'sd0, 8'sd64, -8'sd64, 8'sd32, -8'sd32, 8'sd100, -8'sd100};

  always #5 clk = ~clk;

  pbit_unit i_pbit_unit (
    .clk(clk), .rst(rst), .bias_in(bias_in), .hold_cycles(hold_cycles),
    .clamp_en(clamp_en), .clamp_val(clamp_val), .state_out(state_out)
  );

  function automatic int exp_p(input int x);
    int ax;
    if (x == -128) return 0;
    if (x == 127) return 255;
    ax = (x < 0) ? -x : x;
    return 128 + (127 * x) / (ax + 32);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic check_near(input string req, input int act, input int expv, input int tol);
    n_cmp++;
    if (act > expv + tol || act < expv - tol) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d +/- %0d", req, act, expv, tol);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) step();
    check("R1 reset", int'(state_out), 0);
    rst = 1'b0;
  endtask

  int ones;

  initial begin
    // R2: rail bias, hold 5 -> six clocks between resamples
    hold_cycles = 24'd5;
    bias_in = 8'h7F;
    do_reset();
    step();
    check("R1 first edge resamples", int'(state_out), 1);
    bias_in = 8'h80;
    for (int i = 0; i < 5; i++) begin
      step();
      check("R2 held", int'(state_out), 1);
    end
    step();
    check("R2 resample after H+1", int'(state_out), 0);

    // R3: hold 0 follows bias every edge
    hold_cycles = 24'd0;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      bias_in = (i % 2 == 0) ? 8'h7F : 8'h80;
      step();
      check("R3 every clock", int'(state_out), (i % 2 == 0) ? 1 : 0);
    end

    // R9: hold change mid-hold has no effect until the next reload
    hold_cycles = 24'd3;
    bias_in = 8'h7F;
    do_reset();
    step();
    check("R9 first", int'(state_out), 1);
    hold_cycles = 24'd1;
    bias_in = 8'h80;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R9 old hold kept", int'(state_out), 1);
    end
    step();
    check("R9 resample", int'(state_out), 0);
    bias_in = 8'h7F;
    step();
    check("R9 new hold", int'(state_out), 0);
    step();
    check("R9 new hold end", int'(state_out), 1);

    // R5: rails are exact over many resamples
    hold_cycles = 24'd0;
    do_reset();
    bias_in = 8'h80;
    ones = 0;
    for (int i = 0; i < 512; i++) begin step(); ones += int'(state_out); end
    check("R5 floor", ones, 0);
    bias_in = 8'h7F;
    step();
    ones = 0;
    for (int i = 0; i < 512; i++) begin step(); ones += int'(state_out); end
    check("R5 ceiling", ones, 512);

    // R7: clamp overrides bias in both directions
    clamp_en = 1'b1;
    clamp_val = 1'b0;
    bias_in = 8'h7F;
    step();
    ones = 0;
    for (int i = 0; i < 64; i++) begin step(); ones += int'(state_out); end
    check("R7 clamp low", ones, 0);
    clamp_val = 1'b1;
    bias_in = 8'h80;
    step();
    ones = 0;
    for (int i = 0; i < 64; i++) begin step(); ones += int'(state_out); end
    check("R7 clamp high", ones, 64);
    clamp_en = 1'b0;

    // R4 R6 R8: statistical vectors
    for (int v = 0; v < NV; v++) begin
      bias_in = VEC_X[v];
      step();
      ones = 0;
      for (int i = 0; i < WIN; i++) begin step(); ones += int'(state_out); end
      if (VEC_X[v] == 0)
        check_near("R6 zero bias half", ones, WIN / 2, TOL);
      else
        check_near("R8 R4 mean follows curve", ones, (WIN * exp_p(int'(VEC_X[v]))) / 256, TOL);
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule